// File: doc/BRIEF.md
# Volume Fade-In Controller

This block raises an 8-bit input-volume code in steps toward a programmed target level. The usual starting point is mute (code 0x00). Each step waits for a step interval, measured in sample ticks. The step is then committed only when the audio waveform crosses zero, so the gain change makes no audible click. If no crossing arrives within a selectable timeout, the step is committed anyway.

A fade begins only on a low-to-high transition of the fade enable. It ends in one of three ways:
- The volume reaches the target. The controller then pulses a one-cycle hand-off that starts automatic level control.
- The limiter-detect flag rises. The fade stops at once and the same hand-off pulse is issued.
- A fade-out request arrives. This has priority over everything, so the fade stops silently with no step taken.

The total fade time is roughly the target level times the step interval, divided by the step size.

Top module: `vol_fadein_ctrl`

## Requirements
- R1: After a synchronous reset, `vol_o` is 0x00 (mute), and both `fade_act_o` and `alc_start_o` are 0.
- R2: A fade starts only on a 0-to-1 change of `fade_en_i` while idle. The enable is treated as already high when reset is released. An enable that stays high never starts or restarts a fade. On a start with `vol_o` below the target, `fade_act_o` is 1 from the next cycle.
- R3: Each committed step raises `vol_o` by 1 when `step_sel_i` is 0, and by 2 when it is 1.
- R4: A step becomes pending after N sample ticks, where N = STEP_BASE << `ivl_sel_i`. It is committed at the first later tick that shows a zero crossing. A tick shows a crossing when its sample is zero, or when the sample's sign bit differs from the sign bit at the previous tick.
- R5: If no crossing appears, the pending step is committed on the T-th tick after it became pending, where T = TMO_BASE << `tmo_sel_i`.
- R6: A step that would reach or pass `ref_level_i` sets `vol_o` exactly to `ref_level_i`. The same step ends the fade and raises `alc_start_o` for one cycle.
- R7: While fading, `lim_det_i` ends the fade on the next edge. `vol_o` is held and `alc_start_o` pulses for one cycle.
- R8: `fade_out_i` has priority. While fading, it ends the fade with no step and no hand-off pulse. On the same cycle as an enable rise, it blocks the start.
- R9: A start while `vol_o` is already at or above `ref_level_i` does not activate the fade. It only pulses `alc_start_o`.
- R10: `vol_wr_i` loads `vol_wr_val_i` into the volume while idle. It is ignored while a fade is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe marking a valid audio sample |
| sample_i | input | SAMPLE_W | Signed audio sample, valid with `tick_i` |
| fade_en_i | input | 1 | Fade enable; its rising edge starts a fade |
| fade_out_i | input | 1 | Fade-out request; overrides fade-in |
| ref_level_i | input | 8 | Target volume code |
| step_sel_i | input | 1 | Step size: 0 = 1 code, 1 = 2 codes |
| ivl_sel_i | input | 2 | Step interval select (STEP_BASE << sel ticks) |
| tmo_sel_i | input | 2 | Zero-cross timeout select (TMO_BASE << sel ticks) |
| lim_det_i | input | 1 | Limiter detect flag |
| vol_wr_i | input | 1 | Volume load strobe (idle only) |
| vol_wr_val_i | input | 8 | Volume value to load |
| vol_o | output | 8 | Current volume code |
| fade_act_o | output | 1 | Fade in progress |
| alc_start_o | output | 1 | One-cycle hand-off pulse to automatic level control |

## Verification
The checker watches a fixed set of properties on every cycle:
- each cycle of an active fade raises the volume by at most two codes;
- the volume never passes the target;
- the limiter and fade-out responses take exactly one cycle;
- a hand-off never coincides with an active fade;
- activation always follows a high enable.

Other behaviours need the bench's scenarios, because they depend on counts of ticks and on the contents of the samples:
- the tick at which each step lands, whether set by a zero crossing, a zero sample or the timeout;
- the clamp value on the final step;
- that a write during a fade is dropped;
- that a held enable never restarts a fade.

// File: rtl/fadein_pkg.sv
package fadein_pkg;

    localparam int VOL_W = 8;

    typedef logic [VOL_W-1:0] vol_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RAMP = 1'b1
    } fade_state_e;

    // Result of one ramp step: new code and whether the target was hit.
    typedef struct packed {
        vol_t code;
        logic at_ref;
    } vol_step_t;

    function automatic vol_step_t fi_step_up(vol_t cur, logic big_step, vol_t target);
        logic [VOL_W:0] sum;
        vol_step_t      res;
        sum = {1'b0, cur} + (big_step ? (VOL_W+1)'(2) : (VOL_W+1)'(1));
        if (sum >= {1'b0, target}) begin
            res.code   = target;
            res.at_ref = 1'b1;
        end else begin
            res.code   = sum[VOL_W-1:0];
            res.at_ref = 1'b0;
        end
        return res;
    endfunction

    // Longest interval reachable from a base with a 2-bit shift select.
    function automatic int unsigned fi_len_max(int unsigned base);
        return base << 3;
    endfunction

endpackage

// File: rtl/fi_zc_detect.sv
module fi_zc_detect #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                zc_o
);

    logic prev_sign_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sign_q <= 1'b0;
        end else if (tick_i) begin
            prev_sign_q <= sample_i[SAMPLE_W-1];
        end
    end

    assign zc_o = tick_i & ((sample_i == '0) | (sample_i[SAMPLE_W-1] != prev_sign_q));

endmodule

// File: rtl/fi_step_timer.sv
module fi_step_timer
    import fadein_pkg::*;
#(
    parameter int unsigned STEP_BASE = 4,
    parameter int unsigned TMO_BASE  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic       zc_i,
    input  logic [1:0] ivl_sel_i,
    input  logic [1:0] tmo_sel_i,
    output logic       fire_o
);

    localparam int unsigned LEN_MAX = (fi_len_max(STEP_BASE) > fi_len_max(TMO_BASE)) ?
                                      fi_len_max(STEP_BASE) : fi_len_max(TMO_BASE);
    localparam int CW = $clog2(LEN_MAX + 1);

    typedef logic [CW-1:0] cnt_t;

    cnt_t ivl_tab [4];
    cnt_t tmo_tab [4];
    cnt_t cnt_q, cnt_inc, ivl_len, tmo_len;
    logic pend_q;

    for (genvar g = 0; g < 4; g++) begin : g_len
        assign ivl_tab[g] = cnt_t'(STEP_BASE << g);
        assign tmo_tab[g] = cnt_t'(TMO_BASE << g);
    end

    assign ivl_len = ivl_tab[ivl_sel_i];
    assign tmo_len = tmo_tab[tmo_sel_i];
    assign cnt_inc = cnt_q + cnt_t'(1);

    // One counter serves both phases: interval wait, then crossing wait.
    assign fire_o = run_i & tick_i & pend_q & (zc_i | (cnt_inc == tmo_len));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (tick_i) begin
            if (!pend_q) begin
                if (cnt_inc == ivl_len) begin
                    pend_q <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q  <= cnt_inc;
                end
            end else if (fire_o) begin
                pend_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_inc;
            end
        end
    end

endmodule

// File: rtl/vol_fadein_ctrl.sv
module vol_fadein_ctrl
    import fadein_pkg::*;
#(
    parameter int          SAMPLE_W  = 16,
    parameter int unsigned STEP_BASE = 4,
    parameter int unsigned TMO_BASE  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                fade_en_i,
    input  logic                fade_out_i,
    input  logic [7:0]          ref_level_i,
    input  logic                step_sel_i,
    input  logic [1:0]          ivl_sel_i,
    input  logic [1:0]          tmo_sel_i,
    input  logic                lim_det_i,
    input  logic                vol_wr_i,
    input  logic [7:0]          vol_wr_val_i,
    output logic [7:0]          vol_o,
    output logic                fade_act_o,
    output logic                alc_start_o
);

    fade_state_e state_q, state_d;
    vol_t        vol_q, vol_d;
    logic        alc_q, alc_d;
    logic        en_q, start_req, zc, fire;
    vol_step_t   step;

    fi_zc_detect #(.SAMPLE_W(SAMPLE_W)) u_zc (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .sample_i (sample_i),
        .zc_o     (zc)
    );

    fi_step_timer #(.STEP_BASE(STEP_BASE), .TMO_BASE(TMO_BASE)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .run_i     (state_q == ST_RAMP),
        .tick_i    (tick_i),
        .zc_i      (zc),
        .ivl_sel_i (ivl_sel_i),
        .tmo_sel_i (tmo_sel_i),
        .fire_o    (fire)
    );

    assign start_req = fade_en_i & ~en_q;
    assign step      = fi_step_up(vol_q, step_sel_i, ref_level_i);

    always_comb begin
        state_d = state_q;
        vol_d   = vol_q;
        alc_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req && !fade_out_i) begin
                    if (vol_q >= ref_level_i) alc_d   = 1'b1;
                    else                      state_d = ST_RAMP;
                end else if (vol_wr_i) begin
                    vol_d = vol_wr_val_i;
                end
            end
            ST_RAMP: begin
                if (fade_out_i) begin
                    state_d = ST_IDLE;
                end else if (lim_det_i) begin
                    state_d = ST_IDLE;
                    alc_d   = 1'b1;
                end else if (fire) begin
                    vol_d = step.code;
                    if (step.at_ref) begin
                        state_d = ST_IDLE;
                        alc_d   = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vol_q   <= '0;
            alc_q   <= 1'b0;
            en_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            vol_q   <= vol_d;
            alc_q   <= alc_d;
            en_q    <= fade_en_i;
        end
    end

    assign vol_o       = vol_q;
    assign fade_act_o  = (state_q == ST_RAMP);
    assign alc_start_o = alc_q;

endmodule

// File: rtl/fi_checker.sv
module fi_checker (
    input logic       clk,
    input logic       rst,
    input logic       fade_en_i,
    input logic       fade_out_i,
    input logic       lim_det_i,
    input logic [7:0] ref_level_i,
    input logic [7:0] vol_o,
    input logic       fade_act_o,
    input logic       alc_start_o
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (vol_o == 8'h00 && !fade_act_o && !alc_start_o)); // R1

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(fade_act_o) |-> $past(fade_en_i)); // R2

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        fade_act_o |=> (vol_o >= $past(vol_o)) && ((vol_o - $past(vol_o)) <= 8'd2)); // R3

    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
        (fade_act_o && vol_o < ref_level_i) |=> (vol_o <= $past(ref_level_i))); // R6

    AST_HANDOFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        alc_start_o |-> !fade_act_o); // R6

    AST_LIMIT_STOP: assert property (@(posedge clk) disable iff (rst)
        (fade_act_o && lim_det_i && !fade_out_i) |=> (!fade_act_o && alc_start_o && $stable(vol_o))); // R7

    AST_FADEOUT_WINS: assert property (@(posedge clk) disable iff (rst)
        fade_out_i |=> (!fade_act_o && !alc_start_o)); // R8

    AST_FADEOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fade_out_i && fade_act_o) |=> $stable(vol_o)); // R8

endmodule

bind vol_fadein_ctrl fi_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .fade_en_i   (fade_en_i),
    .fade_out_i  (fade_out_i),
    .lim_det_i   (lim_det_i),
    .ref_level_i (ref_level_i),
    .vol_o       (vol_o),
    .fade_act_o  (fade_act_o),
    .alc_start_o (alc_start_o)
);

// File: tb/vol_fadein_ctrl_tb.sv
`timescale 1ns/1ps
module vol_fadein_ctrl_tb;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               tick = 1'b0;
    logic signed [15:0] sample = '0;
    logic               fade_en = 1'b1;
    logic               fade_out = 1'b0;
    logic [7:0]         ref_lvl = 8'd0;
    logic               step_sel = 1'b0;
    logic [1:0]         ivl_sel = 2'd0;
    logic [1:0]         tmo_sel = 2'd0;
    logic               lim_det = 1'b0;
    logic               vol_wr = 1'b0;
    logic [7:0]         vol_wr_val = 8'd0;
    logic [7:0]         vol;
    logic               fade_act;
    logic               alc_start;

    typedef struct {
        int    vol;
        int    tick;
        string req;
    } exp_t;

    exp_t       sb_q[$];
    int         checks = 0;
    int         errors = 0;
    int         tick_num = 0;
    int         alc_cnt = 0;
    int         model_vol = 0;
    logic [7:0] last_vol = 8'h00;
    bit         done = 0;

    always #10 clk = ~clk;

    vol_fadein_ctrl u_dut (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .sample_i     (sample),
        .fade_en_i    (fade_en),
        .fade_out_i   (fade_out),
        .ref_level_i  (ref_lvl),
        .step_sel_i   (step_sel),
        .ivl_sel_i    (ivl_sel),
        .tmo_sel_i    (tmo_sel),
        .lim_det_i    (lim_det),
        .vol_wr_i     (vol_wr),
        .vol_wr_val_i (vol_wr_val),
        .vol_o        (vol),
        .fade_act_o   (fade_act),
        .alc_start_o  (alc_start)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_step(int v, int t, string req);
        exp_t e;
        e.vol = v; e.tick = t; e.req = req;
        sb_q.push_back(e);
        model_vol = v;
    endtask

    // Monitor: every change of the volume must match the next queued item.
    always @(negedge clk) begin
        if (rst) begin
            last_vol = 8'h00;
        end else begin
            if (vol !== last_vol) begin
                if (sb_q.size() == 0) begin
                    check(0, "R10", "unexpected volume change", int'(vol), int'(last_vol));
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(int'(vol) == e.vol, e.req, "volume value", int'(vol), e.vol);
                    check(tick_num == e.tick, e.req, "step tick", tick_num, e.tick);
                end
                last_vol = vol;
            end
            if (alc_start) alc_cnt++;
        end
    end

    // mode 0: constant positive, 1: alternating sign, 2: all zero
    task automatic run_ticks(int n, int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_num++;
            tick = 1'b1;
            case (mode)
                0:       sample = 16'sd100;
                1:       sample = (tick_num % 2 == 1) ? 16'sd60 : -16'sd60;
                default: sample = 16'sd0;
            endcase
            @(negedge clk);
            tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic write_vol(int v);
        @(negedge clk);
        vol_wr = 1'b1;
        vol_wr_val = 8'(v);
        if (v != model_vol) expect_step(v, tick_num, "R10");
        @(negedge clk);
        vol_wr = 1'b0;
    endtask

    task automatic start_fade();
        @(negedge clk);
        fade_en = 1'b0;
        alc_cnt = 0;
        @(negedge clk);
        fade_en = 1'b1;
        @(negedge clk);
        tick_num = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(vol == 8'h00, "R1", "vol after reset", int'(vol), 0);
        check(fade_act == 1'b0, "R1", "fade_act after reset", int'(fade_act), 0);
        check(alc_start == 1'b0, "R1", "alc_start after reset", int'(alc_start), 0);
        repeat (4) @(negedge clk);
        check(fade_act == 1'b0, "R2", "held enable from reset starts nothing", int'(fade_act), 0);

        // Timeout-driven ramp, step 2, N=4, T=2, no crossings
        ref_lvl = 8'd6; step_sel = 1'b1; ivl_sel = 2'd0; tmo_sel = 2'd0;
        start_fade();
        check(fade_act == 1'b1, "R2", "fade starts on enable rise", int'(fade_act), 1);
        expect_step(2, 6, "R5");
        expect_step(4, 12, "R5");
        expect_step(6, 18, "R6");
        run_ticks(20, 0);
        check(fade_act == 1'b0, "R6", "fade ends at target", int'(fade_act), 0);
        check(alc_cnt == 1, "R6", "handoff pulses at target", alc_cnt, 1);
        repeat (4) @(negedge clk);
        check(fade_act == 1'b0, "R2", "held enable does not restart", int'(fade_act), 0);

        // Crossing-driven ramp, step 1, N=8, long timeout
        write_vol(0);
        ref_lvl = 8'd3; step_sel = 1'b0; ivl_sel = 2'd1; tmo_sel = 2'd3;
        start_fade();
        expect_step(1, 9, "R4");
        expect_step(2, 18, "R3");
        expect_step(3, 27, "R4");
        run_ticks(30, 1);
        check(alc_cnt == 1, "R6", "handoff after crossing ramp", alc_cnt, 1);

        // Clamp: step 2 from 2 to target 3, N=4, T=4
        write_vol(0);
        ref_lvl = 8'd3; step_sel = 1'b1; ivl_sel = 2'd0; tmo_sel = 2'd1;
        start_fade();
        expect_step(2, 8, "R5");
        expect_step(3, 16, "R6");
        run_ticks(18, 0);
        check(int'(vol) == 3, "R6", "clamped to target", int'(vol), 3);
        check(fade_act == 1'b0, "R6", "clamp ends fade", int'(fade_act), 0);

        // Zero samples count as crossings, write ignored, limiter stop
        write_vol(0);
        ref_lvl = 8'd10; step_sel = 1'b1; ivl_sel = 2'd2; tmo_sel = 2'd3;
        start_fade();
        expect_step(2, 17, "R4");
        run_ticks(17, 2);
        @(negedge clk);
        vol_wr = 1'b1; vol_wr_val = 8'd50;
        @(negedge clk);
        vol_wr = 1'b0;
        @(negedge clk);
        check(int'(vol) == 2, "R10", "write ignored while active", int'(vol), 2);
        check(fade_act == 1'b1, "R10", "still active after write", int'(fade_act), 1);
        lim_det = 1'b1;
        @(negedge clk);
        lim_det = 1'b0;
        @(negedge clk);
        check(fade_act == 1'b0, "R7", "limiter ends fade", int'(fade_act), 0);
        check(alc_cnt == 1, "R7", "limiter handoff pulse", alc_cnt, 1);
        check(int'(vol) == 2, "R7", "limiter holds volume", int'(vol), 2);

        // Fade-out aborts an active fade
        write_vol(0);
        ref_lvl = 8'd10; step_sel = 1'b1; ivl_sel = 2'd0; tmo_sel = 2'd0;
        start_fade();
        expect_step(2, 6, "R5");
        run_ticks(7, 0);
        @(negedge clk);
        fade_out = 1'b1;
        @(negedge clk);
        fade_out = 1'b0;
        @(negedge clk);
        check(fade_act == 1'b0, "R8", "fade-out ends fade", int'(fade_act), 0);
        check(alc_cnt == 0, "R8", "no handoff on fade-out", alc_cnt, 0);
        run_ticks(12, 0);
        check(int'(vol) == 2, "R8", "no step after fade-out", int'(vol), 2);

        // Fade-out on the same cycle as enable rise blocks the start
        @(negedge clk);
        fade_en = 1'b0;
        alc_cnt = 0;
        @(negedge clk);
        fade_en = 1'b1;
        fade_out = 1'b1;
        @(negedge clk);
        fade_out = 1'b0;
        @(negedge clk);
        check(fade_act == 1'b0, "R8", "simultaneous fade-out blocks start", int'(fade_act), 0);
        repeat (3) @(negedge clk);
        check(fade_act == 1'b0, "R2", "no start without fresh edge", int'(fade_act), 0);
        check(alc_cnt == 0, "R8", "no handoff when blocked", alc_cnt, 0);

        // Start with volume already at or above target
        write_vol(10);
        ref_lvl = 8'd5;
        start_fade();
        @(negedge clk);
        check(fade_act == 1'b0, "R9", "no fade when above target", int'(fade_act), 0);
        check(alc_cnt == 1, "R9", "handoff when above target", alc_cnt, 1);
        check(int'(vol) == 10, "R9", "volume unchanged", int'(vol), 10);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R4", "all expected steps seen", sb_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule